// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between two active-low external interrupt pins and a small CPU core. It brings each pin into the clock domain through a two-flop synchronizer and turns the results into request lines for the core. The first pin, the maskable line, is edge-sensitive by default. In that mode a falling edge is captured into a pending flag. The flag stays set until the core pulses a one-cycle service acknowledge. Software may instead select level sensing, which suits several open-collector sources wired onto one line. That choice can only be made during a short window after reset.

The second pin, the non-maskable line, is always level-sensitive and does not respond to the CPU global mask. Its own mask bit is set by reset. Software can clear this bit, but it cannot set it again. While the core is stopped, a low level on either pin raises a wake output, whatever the masks are.

Top module: `xreq_conditioner`

## Requirements
- R1: During and right after reset, `mreq`, `nmreq` and `wake` are 0. The maskable line is in edge mode and the non-maskable mask bit is set.
- R2: In edge mode, a falling edge on `mreq_pin_n` sets a pending flag. The flag keeps `mreq` high after the pin returns high. A pin held low yields only one pending request.
- R3: A one-cycle `req_ack` clears the pending flag, unless a new falling edge is detected in the same cycle.
- R4: When `opt_wr` writes `opt_edge`=0 inside the window, the maskable line becomes level-sensitive. `mreq` then follows the synchronized low level, and `req_ack` has no effect.
- R5: Option writes that arrive once `WINDOW` (64) clock cycles have passed after reset are ignored. The mode stays as it was.
- R6: `mreq` is forced to 0 while `cpu_i_mask`=1. A pending edge request survives the masked period and appears when the mask clears.
- R7: `nmreq` is high while `nmreq_pin_n` is low (synchronized) and the non-maskable mask bit is clear. It does not depend on `cpu_i_mask`.
- R8: Writing `x_wdata`=0 with `x_wr` clears the non-maskable mask bit. Writing 1 is ignored, and only reset sets the bit again.
- R9: While `core_stopped`=1, `wake` is high whenever either synchronized pin is low, even with the non-maskable mask set. In that case `nmreq` stays 0.
- R10: A pin change passes through two flops. Level-driven outputs respond after the second clock edge, and a latched edge request after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_pin_n | input | 1 | Maskable request pin, active low, asynchronous |
| nmreq_pin_n | input | 1 | Non-maskable request pin, active low, asynchronous |
| cpu_i_mask | input | 1 | CPU global interrupt mask (1 = masked) |
| x_wr | input | 1 | Write strobe for the non-maskable mask bit |
| x_wdata | input | 1 | Value written to the non-maskable mask bit (only 0 takes effect) |
| opt_wr | input | 1 | Write strobe for the trigger option bit |
| opt_edge | input | 1 | Option value: 1 = edge mode, 0 = level mode |
| req_ack | input | 1 | One-cycle acknowledge from the core for the pending edge request |
| core_stopped | input | 1 | Core is in its stopped low-power state |
| mreq | output | 1 | Maskable request to the core |
| nmreq | output | 1 | Non-maskable request to the core |
| wake | output | 1 | Wake request for a stopped core |

## Verification
The assertions assume the following about the inputs:
- `req_ack` is a single-cycle pulse.
- The option and mask write strobes change only between clock edges.
- The block is clocked while the core is stopped, so the synchronizers keep sampling.

The stimulus respects these assumptions:
- All inputs change at the falling clock edge.
- Every acknowledge lasts exactly one cycle.
- The clock is never gated.

Pins are held for at least three cycles per step, so every change passes the synchronizer and the edge detector before it is sampled.

// File: rtl/xreq_pkg.sv
package xreq_pkg;

    localparam int SYNC_STAGES_DEF = 2;
    localparam int WINDOW_DEF      = 64;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    // synchronized pin levels, converted to active-high "asserted"
    typedef struct packed {
        logic mask_line;
        logic nm_line;
    } line_lvl_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;   // pins idle high
            else     chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/xreq_ctrl.sv
module xreq_ctrl
    import xreq_pkg::*;
#(
    parameter int WINDOW = WINDOW_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       opt_wr,
    input  logic       opt_edge,
    input  logic       x_wr,
    input  logic       x_wdata,
    output trig_mode_e mode,
    output logic       x_mask
);
    localparam int CW = cnt_width(WINDOW);

    logic [CW-1:0] age;
    logic          win_open;

    assign win_open = (age < CW'(WINDOW));

    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (win_open) age <= age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                      mode <= TRIG_EDGE;
        else if (opt_wr && win_open)  mode <= opt_edge ? TRIG_EDGE : TRIG_LEVEL;
    end

    // clear-only mask: a write of 1 is dropped
    always_ff @(posedge clk) begin
        if (rst)                 x_mask <= 1'b1;
        else if (x_wr && !x_wdata) x_mask <= 1'b0;
    end

    p_lock_r5: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> $stable(mode))
        else $error("R5: trigger option changed after window closed");

    p_xset_r8: assert property (@(posedge clk) disable iff (rst)
        !x_mask |=> !x_mask)
        else $error("R8: non-maskable mask set again without reset");

endmodule

// File: rtl/xreq_latch.sv
module xreq_latch
    import xreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       act,
    input  trig_mode_e mode,
    input  logic       ack,
    output logic       pend
);
    logic act_d;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) act_d <= 1'b0;
        else     act_d <= act;
    end

    assign fall = act && !act_d;

    always_ff @(posedge clk) begin
        if (rst || mode == TRIG_LEVEL) pend <= 1'b0;
        else if (fall)                 pend <= 1'b1;
        else if (ack)                  pend <= 1'b0;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack && mode == TRIG_EDGE) |=> pend)
        else $error("R2: pending request lost without acknowledge");

    p_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (ack && !fall) |=> !pend)
        else $error("R3: acknowledge did not clear pending request");

endmodule

// File: rtl/xreq_conditioner.sv
module xreq_conditioner
    import xreq_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int WINDOW      = WINDOW_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic mreq_pin_n,
    input  logic nmreq_pin_n,
    input  logic cpu_i_mask,
    input  logic x_wr,
    input  logic x_wdata,
    input  logic opt_wr,
    input  logic opt_edge,
    input  logic req_ack,
    input  logic core_stopped,
    output logic mreq,
    output logic nmreq,
    output logic wake
);
    logic [1:0]  pins_q;
    line_lvl_t   lvl;
    trig_mode_e  mode;
    logic        x_mask;
    logic        pend;

    xreq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mreq_pin_n, nmreq_pin_n}),
        .q   (pins_q)
    );

    assign lvl.mask_line = !pins_q[1];
    assign lvl.nm_line   = !pins_q[0];

    xreq_ctrl #(.WINDOW(WINDOW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opt_wr   (opt_wr),
        .opt_edge (opt_edge),
        .x_wr     (x_wr),
        .x_wdata  (x_wdata),
        .mode     (mode),
        .x_mask   (x_mask)
    );

    xreq_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .act  (lvl.mask_line),
        .mode (mode),
        .ack  (req_ack),
        .pend (pend)
    );

    assign mreq  = ((mode == TRIG_EDGE) ? pend : lvl.mask_line) && !cpu_i_mask;
    assign nmreq = lvl.nm_line && !x_mask;
    assign wake  = core_stopped && (lvl.mask_line || lvl.nm_line);

endmodule

// File: tb/sim_xreq_conditioner.sv
module sim_xreq_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    // bits: [7]m_pin_n [6]nm_pin_n [5]i_mask [4]stopped [3]ack [2]exp_mreq [1]exp_nmreq [0]exp_wake
    localparam logic [7:0] TBL [0:NVEC-1] = '{
        8'b11000000,  // idle
        8'b01000100,  // R2 fall latched
        8'b11000100,  // R2 held after release
        8'b11001000,  // R3 ack clears
        8'b01100000,  // R6 fall while masked
        8'b11000100,  // R6 pending shows after unmask
        8'b11001000,  // R3 ack
        8'b01000100,  // R2 new edge
        8'b01001000,  // R2 held low, ack, no second request
        8'b11000000,  // release, nothing
        8'b10000000,  // R7 nm low, mask set -> no nmreq
        8'b10010001,  // R9 stopped, nm low -> wake, no nmreq
        8'b01110001,  // R9 maskable low wakes even when masked
        8'b11001000,  // R3 clear pending
        8'b11010000   // R9 no wake when pins high
    };

    logic clk = 1'b0;
    logic rst, m_n, nm_n, imask, x_wr, x_wd, opt_wr, opt_e, ack, stopped;
    logic mreq, nmreq, wake;
    int   nchk = 0;
    int   nbad = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xreq_conditioner u0 (
        .clk(clk), .rst(rst), .mreq_pin_n(m_n), .nmreq_pin_n(nm_n),
        .cpu_i_mask(imask), .x_wr(x_wr), .x_wdata(x_wd), .opt_wr(opt_wr),
        .opt_edge(opt_e), .req_ack(ack), .core_stopped(stopped),
        .mreq(mreq), .nmreq(nmreq), .wake(wake)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; m_n = 1; nm_n = 1; imask = 0; x_wr = 0; x_wd = 1;
        opt_wr = 0; opt_e = 1; ack = 0; stopped = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    // drive at negedge, optional one-cycle ack, sample after three edges
    task automatic step(input logic mp, input logic np, input logic im,
                        input logic st, input logic ak);
        m_n = mp; nm_n = np; imask = im; stopped = st; ack = ak;
        @(negedge clk); ack = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 mreq", mreq, 1'b0);
        chk("R1 nmreq", nmreq, 1'b0);
        chk("R1 wake", wake, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i][7], TBL[i][6], TBL[i][5], TBL[i][4], TBL[i][3]);
            chk($sformatf("vec%0d R2/R3/R6/R7/R9 mreq", i), mreq, TBL[i][2]);
            chk($sformatf("vec%0d R7 nmreq", i), nmreq, TBL[i][1]);
            chk($sformatf("vec%0d R9 wake", i), wake, TBL[i][0]);
        end

        // R7 / R8: clear X, nm line ignores global mask; writing 1 ignored
        do_reset();
        x_wr = 1; x_wd = 0; @(negedge clk); x_wr = 0;
        step(1, 0, 1, 0, 0);
        chk("R7 nmreq with i_mask set", nmreq, 1'b1);
        x_wr = 1; x_wd = 1; @(negedge clk); x_wr = 0;
        chk("R8 write 1 ignored", nmreq, 1'b1);
        do_reset();
        step(1, 0, 0, 0, 0);
        chk("R8 reset sets mask again", nmreq, 1'b0);

        // R4 level mode inside window
        do_reset();
        opt_wr = 1; opt_e = 0; @(negedge clk); opt_wr = 0;
        step(0, 1, 0, 0, 0);
        chk("R4 level low", mreq, 1'b1);
        step(0, 1, 0, 0, 1);
        chk("R4 ack no effect", mreq, 1'b1);
        step(1, 1, 0, 0, 0);
        chk("R4 follows release", mreq, 1'b0);

        // R5 late write ignored: still edge mode
        do_reset();
        repeat (70) @(negedge clk);
        opt_wr = 1; opt_e = 0; @(negedge clk); opt_wr = 0;
        step(0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        chk("R5 still latched after release", mreq, 1'b1);

        // R10 latency, edge request
        do_reset();
        m_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R10 edge not yet after 2 edges", mreq, 1'b0);
        @(negedge clk);
        chk("R10 edge after 3 edges", mreq, 1'b1);
        // R10 latency, level-driven wake
        do_reset();
        stopped = 1; nm_n = 0;
        @(negedge clk);
        chk("R10 wake not after 1 edge", wake, 1'b0);
        @(negedge clk);
        chk("R10 wake after 2 edges", wake, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule